// File: doc/BRIEF.md
# Multichannel Digital Silence Detector

This block watches six parallel audio channels, each presenting one 24-bit sample per frame. A one-cycle sample strobe marks each new frame. It counts how many frames in a row every participating channel has held an all-zero sample. When that run reaches a fixed threshold, it pulls an active-low silence flag low. Logic further along the chip can use the flag to mute an output stage or to stop a recorder while no program material is present.

Which channels take part depends on the control mode. In static mode all six channels take part and the mask is ignored. In register mode a per-channel participation mask decides. A digital mute indication also forces the flag low, because muted output is silent by definition. The block neither alters nor passes audio data.

Top module: `multich_silence_det`

## Requirements
- R1: `silenceN` is active low. While `rstN` is low, and after reset until the threshold is reached, it reads 1 (unless mute is active). An asynchronous reset also discards any silence run in progress.
- R2: `silenceN` goes to 0 right after the clock edge that accepts the THRESHOLD-th consecutive silent frame (default 9600). After THRESHOLD-1 such frames it still reads 1.
- R3: With `staticMode`=1, all channels participate whatever the value of `partMask`.
- R4: With `staticMode`=0, channel i participates when `partMask[i]`=1 and is excluded when it is 0. Bit i of `partMask` maps to `sampleIn[i]`. A nonzero sample on an excluded channel neither breaks nor delays a silence run.
- R5: A strobed frame with a nonzero sample on any participating channel restarts the run. The flag returns to 1 immediately after that edge (unless mute is active).
- R6: The run length saturates at THRESHOLD. Any number of further silent frames keeps the flag at 0, and the count never wraps.
- R7: In register mode with `partMask`=0, every strobed frame restarts the run, so the flag follows only `muteActive`.
- R8: `muteActive`=1 drives `silenceN` to 0 in the same cycle, in any mode and at any count.
- R9: Cycles without `sampleStrobe` neither advance nor restart the run, whatever the sample values.
- R10: A sample counts as nonzero if any single bit is set, including only bit 0 or only bit 23.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleStrobe | input | 1 | Marks the cycle that carries a new frame |
| sampleIn | input | NUM_CH x SAMPLE_W | One sample per channel, index i = channel i |
| partMask | input | NUM_CH | Per-channel participation in register mode (1 = participates) |
| staticMode | input | 1 | 1 = all channels participate, 0 = mask controls |
| muteActive | input | 1 | Digital mute indication; forces the flag low |
| silenceN | output | 1 | Active-low silence flag |

## Verification
Almost all internal state is the run counter. An off-by-one in the counter or in its saturation moves the edge where the flag falls: it shows at the first frame when the count reaches the threshold, or as a release while silence continues. A wrong participation decision shows at the first strobe where an excluded channel carries data or an included one does. The flag then falls or releases one frame too early, or never falls at all. The exhaustive mask-by-channel sweep exposes such a fault within one threshold-length run. A mute or strobe-gating fault shows in the same cycle as the stimulus.

// File: rtl/silence_det_pkg.sv
package silence_det_pkg;
  // Strobes from the control unit to the run counter
  typedef struct packed {
    logic advance;  // silent frame accepted: count up (saturating)
    logic restart;  // frame broke silence or nobody participates: back to zero
  } run_ctrl_t;
endpackage

// File: rtl/silence_det_datapath.sv
module silence_det_datapath
  import silence_det_pkg::*;
#(
  parameter int NUM_CH    = 6,
  parameter int SAMPLE_W  = 24,
  parameter int THRESHOLD = 9600,
  parameter int CNT_W     = $clog2(THRESHOLD + 1)
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  run_ctrl_t                        ctrl,
  input  logic [NUM_CH-1:0][SAMPLE_W-1:0]  sampleIn,
  output logic [NUM_CH-1:0]                chanZero,
  output logic [CNT_W-1:0]                 frameCnt,
  output logic                             cntFull
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(THRESHOLD);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  // Per-channel all-zero detection across the full sample width
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_zero
    assign chanZero[ch] = ~(|sampleIn[ch]);
  end

  assign cntFull = (frameCnt == LIMIT);

  // Saturating run counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameCnt <= '0;
    end else if (ctrl.restart) begin
      frameCnt <= '0;
    end else if (ctrl.advance && !cntFull) begin
      frameCnt <= frameCnt + ONE;
    end
  end
endmodule

// File: rtl/silence_det_control.sv
module silence_det_control
  import silence_det_pkg::*;
#(
  parameter int NUM_CH = 6
) (
  input  logic              sampleStrobe,
  input  logic              staticMode,
  input  logic [NUM_CH-1:0] partMask,
  input  logic [NUM_CH-1:0] chanZero,
  input  logic              cntFull,
  input  logic              muteActive,
  output run_ctrl_t         ctrl,
  output logic              silenceN
);
  logic [NUM_CH-1:0] effMask;
  logic              anyPart;
  logic              frameQuiet;

  // Static mode forces every channel into the decision
  always_comb begin
    effMask    = staticMode ? {NUM_CH{1'b1}} : partMask;
    anyPart    = |effMask;
    frameQuiet = anyPart && (&(chanZero | ~effMask));
  end

  always_comb begin
    ctrl.advance = sampleStrobe && frameQuiet;
    ctrl.restart = sampleStrobe && !frameQuiet;
  end

  // Mute takes effect without waiting for a frame
  assign silenceN = ~(muteActive | cntFull);
endmodule

// File: rtl/multich_silence_det.sv
module multich_silence_det
  import silence_det_pkg::*;
#(
  parameter int NUM_CH    = 6,
  parameter int SAMPLE_W  = 24,
  parameter int THRESHOLD = 9600
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             sampleStrobe,
  input  logic [NUM_CH-1:0][SAMPLE_W-1:0]  sampleIn,
  input  logic [NUM_CH-1:0]                partMask,
  input  logic                             staticMode,
  input  logic                             muteActive,
  output logic                             silenceN
);
  localparam int CNT_W = $clog2(THRESHOLD + 1);

  run_ctrl_t         runCtrl;
  logic [NUM_CH-1:0] chanZero;
  logic [CNT_W-1:0]  frameCnt;
  logic              cntFull;

  silence_det_datapath #(
    .NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .THRESHOLD(THRESHOLD), .CNT_W(CNT_W)
  ) datapath_i (
    .clk(clk), .rstN(rstN), .ctrl(runCtrl), .sampleIn(sampleIn),
    .chanZero(chanZero), .frameCnt(frameCnt), .cntFull(cntFull)
  );

  silence_det_control #(.NUM_CH(NUM_CH)) control_i (
    .sampleStrobe(sampleStrobe), .staticMode(staticMode), .partMask(partMask),
    .chanZero(chanZero), .cntFull(cntFull), .muteActive(muteActive),
    .ctrl(runCtrl), .silenceN(silenceN)
  );
endmodule

// File: rtl/silence_det_checker.sv
module silence_det_checker #(
  parameter int NUM_CH    = 6,
  parameter int SAMPLE_W  = 24,
  parameter int THRESHOLD = 9600,
  parameter int CNT_W     = $clog2(THRESHOLD + 1)
) (
  input logic                             clk,
  input logic                             rstN,
  input logic                             sampleStrobe,
  input logic [NUM_CH-1:0][SAMPLE_W-1:0]  sampleIn,
  input logic [NUM_CH-1:0]                partMask,
  input logic                             staticMode,
  input logic                             muteActive,
  input logic                             silenceN,
  input logic [CNT_W-1:0]                 frameCnt
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(THRESHOLD);

  logic [NUM_CH-1:0] busy;
  logic [NUM_CH-1:0] inRun;
  logic              partNz;
  logic              someoneIn;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_busy
    assign busy[ch]  = (sampleIn[ch] != '0);
    assign inRun[ch] = staticMode | partMask[ch];
  end
  assign partNz    = |(busy & inRun);
  assign someoneIn = |inRun;

  AST_MUTE_FORCES_LOW: assert property (@(posedge clk) disable iff (!rstN)
    muteActive |-> !silenceN);  // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    frameCnt <= LIMIT);  // R6
  AST_FLAG_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (!silenceN && !muteActive) |-> frameCnt == LIMIT);  // R2
  AST_NONZERO_RESTARTS: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStrobe && partNz) |=> frameCnt == '0);  // R5
  AST_NOBODY_RESTARTS: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStrobe && !someoneIn) |=> frameCnt == '0);  // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !sampleStrobe |=> $stable(frameCnt));  // R9
  AST_QUIET_STEPS: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStrobe && someoneIn && !partNz) |=>
      frameCnt == (($past(frameCnt) == LIMIT) ? LIMIT : $past(frameCnt) + CNT_W'(1)));  // R2
endmodule

bind multich_silence_det silence_det_checker #(
  .NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .THRESHOLD(THRESHOLD)
) checker_i (
  .clk(clk), .rstN(rstN), .sampleStrobe(sampleStrobe), .sampleIn(sampleIn),
  .partMask(partMask), .staticMode(staticMode), .muteActive(muteActive),
  .silenceN(silenceN), .frameCnt(frameCnt)
);

// File: tb/multich_silence_det_tb_top.sv
module multich_silence_det_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH     = 6;
  localparam int SAMPLE_W   = 24;
  localparam int TH         = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleStrobe = 1'b0;
  logic staticMode = 1'b1;
  logic muteActive = 1'b0;
  logic [NUM_CH-1:0] partMask = '1;
  logic [NUM_CH-1:0][SAMPLE_W-1:0] sampleIn = '0;
  logic silenceN;

  int nCmp = 0;
  int nBad = 0;
  int expCnt = 0;
  bit finished = 1'b0;

  multich_silence_det #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .THRESHOLD(TH)) dut_i (
    .clk(clk), .rstN(rstN), .sampleStrobe(sampleStrobe), .sampleIn(sampleIn),
    .partMask(partMask), .staticMode(staticMode), .muteActive(muteActive),
    .silenceN(silenceN)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic expFlag();
    return !(muteActive || (expCnt == TH));
  endfunction

  task automatic check(string req);
    logic exp;
    exp = expFlag();
    nCmp++;
    if (silenceN !== exp) begin
      nBad++;
      $display("FAIL %s: silenceN=%b expected %b (run=%0d)", req, silenceN, exp, expCnt);
    end
  endtask

  // Model of one accepted frame, written from the requirements
  task automatic modelFrame();
    logic [NUM_CH-1:0] part;
    bit loud;
    part = staticMode ? {NUM_CH{1'b1}} : partMask;
    loud = 1'b0;
    for (int c = 0; c < NUM_CH; c++) if (part[c] && sampleIn[c] != '0) loud = 1'b1;
    if (part == '0 || loud) expCnt = 0;
    else if (expCnt < TH) expCnt++;
  endtask

  // Called right after a negedge; returns at the next negedge
  task automatic frame(string req);
    sampleStrobe = 1'b1;
    @(posedge clk);
    modelFrame();
    @(negedge clk);
    sampleStrobe = 1'b0;
    check(req);
  endtask

  task automatic idle(string req);
    sampleStrobe = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(req);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1'b1;
      nBad++;
      $display("FAIL watchdog: run did not end");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state
    @(negedge clk);
    @(negedge clk);
    check("R1");
    rstN = 1'b1;
    idle("R1");

    // R2 / R6 / R3: static mode, mask zero is ignored
    staticMode = 1'b1;
    partMask = '0;
    for (int k = 0; k < TH + 6; k++) frame(k < TH - 1 ? "R2" : "R6");

    // R3 / R5: nonzero on a masked-off channel still counts in static mode
    sampleIn[3] = 24'h000400;
    frame("R3");
    sampleIn = '0;
    for (int k = 0; k < TH - 2; k++) frame("R2");
    // R9: idle cycles with loud data change nothing
    for (int c = 0; c < NUM_CH; c++) sampleIn[c] = 24'hFFFFFF;
    for (int k = 0; k < 5; k++) idle("R9");
    sampleIn = '0;
    frame("R9");
    frame("R2");
    for (int c = 0; c < NUM_CH; c++) sampleIn[c] = 24'h5A5A5A;
    for (int k = 0; k < 3; k++) idle("R9");
    sampleIn = '0;

    // R8: mute forces low in the same cycle
    muteActive = 1'b1;
    idle("R8");
    sampleIn[0] = 24'h1;
    frame("R8");
    sampleIn = '0;
    frame("R8");
    muteActive = 1'b0;
    idle("R8");

    // R4 / R10 / R7: exhaustive mask x channel sweep in register mode
    staticMode = 1'b0;
    for (int m = 0; m < (1 << NUM_CH); m++) begin
      for (int j = 0; j < NUM_CH; j++) begin
        partMask = NUM_CH'(m);
        for (int c = 0; c < NUM_CH; c++) sampleIn[c] = 24'h010101;
        frame(m == 0 ? "R7" : "R5");
        for (int c = 0; c < NUM_CH; c++)
          sampleIn[c] = partMask[c] ? '0 : (SAMPLE_W'(c + 1) << (m % 18));
        for (int k = 0; k < TH; k++) frame(m == 0 ? "R7" : "R4");
        sampleIn = '0;
        sampleIn[j] = (j % 2 == 0) ? 24'h000001 : 24'h800000;
        frame("R10");
        sampleIn = '0;
      end
    end

    // R7: no participants, long silence, flag follows mute only
    partMask = '0;
    for (int k = 0; k < 2 * TH; k++) frame("R7");
    muteActive = 1'b1;
    frame("R7");
    muteActive = 1'b0;
    idle("R7");

    // R1: reset mid-run discards progress
    partMask = 6'b100001;
    for (int k = 0; k < TH - 1; k++) frame("R2");
    rstN = 1'b0;
    expCnt = 0;
    @(negedge clk);
    check("R1");
    rstN = 1'b1;
    for (int k = 0; k < TH - 1; k++) frame("R1");
    frame("R2");

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule